// File: doc/BRIEF.md
# Load/Store Transfer Address and Data Formatter

This block carries out one single-register memory transfer: a word, a byte, a halfword or a sign-extended load. It takes the low 26 bits of the instruction word, the values of the base, offset and data registers, and the program counter. The effective address comes from the base and an offset. The offset is added or subtracted, either before the access (pre-index) or after it (post-index). The block issues one memory request and waits for the response. It then pulses the register-file write strobes for the loaded data register and for the updated base register.

Two encoding classes are decoded, and the `half_fmt` input selects between them. The word/byte class takes a 12-bit immediate or a shifted register as its offset. The halfword/signed class takes a split 8-bit immediate or a plain register as its offset. Encodings that are not allowed do not reach memory. They raise a one-cycle fault pulse and change no register.

Top module: `lsu_xfer_fmt`

## Requirements
- R1: In the word/byte class, instr[25]=0 selects the offset instr[11:0] zero-extended. instr[25]=1 selects the offset register value shifted by instr[11:7] places, with the type in instr[6:5] (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right). A shift amount of 0 leaves the value unchanged for every type. instr[25]=1 together with instr[4]=1 is invalid.
- R2: In the halfword class, instr[22]=1 selects the 8-bit offset {instr[11:8], instr[3:0]}. instr[22]=0 selects the offset register value, and an offset register number instr[3:0]=15 is then invalid.
- R3: instr[23]=1 adds the offset to the base and instr[23]=0 subtracts it.
- R4: With instr[24]=1 the memory address is base±offset. With instr[24]=0 the memory address is the unmodified base. In both cases the value written back to the base is base±offset.
- R5: The base register (number instr[19:16]) is written back when instr[21]=1 or instr[24]=0. The combination instr[24]=0 with instr[21]=1 is invalid.
- R6: In the word/byte class, instr[22]=1 selects a byte access and instr[20]=1 selects a load. `mem_size` is 0 for a byte, 1 for a halfword and 2 for a word. A byte load returns mem_rdata[7:0] zero-extended.
- R7: In the halfword class the access is selected by instr[6] (S), instr[5] (H) and instr[20] (L). S alone stores a byte and S with L loads a sign-extended byte. H stores a halfword whether or not S is set. H with L loads a zero-extended halfword, and H with S and L loads a sign-extended halfword. S=H=0 is invalid.
- R8: In the word/byte class, a base register number of 15 uses pc+4 as the base, and any writeback is then invalid.
- R9: Store data is the data register value with the bits above the access size cleared. When the data register number instr[15:12] is 15, the value stored is that register value plus 8.
- R10: `mem_req_valid` rises in the cycle after an accepted `start` and holds, with address, size, write enable and write data stable, until the first cycle with `mem_resp_valid`. The write strobes `rd_we` and `rb_we` pulse for exactly the following cycle. `rd_we` is high only for loads.
- R11: An invalid encoding at `start` gives a one-cycle `fault` pulse in the next cycle. No memory request and no register write follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; sampled while idle |
| half_fmt | input | 1 | 1 = halfword/signed class, 0 = word/byte class |
| instr | input | 26 | Instruction bits [25:0] |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value |
| data_val | input | 32 | Data register value, used for stores |
| pc_val | input | 32 | Program counter |
| mem_req_valid | output | 1 | Memory request valid |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_we | output | 1 | 1 = store |
| mem_wdata | output | 32 | Store data, right-aligned |
| mem_resp_valid | input | 1 | Memory response/completion |
| mem_rdata | input | 32 | Load data, right-aligned |
| rd_we | output | 1 | Data register write strobe |
| rd_idx | output | 4 | Data register number |
| rd_data | output | 32 | Extended load result |
| rb_we | output | 1 | Base register write strobe |
| rb_idx | output | 4 | Base register number |
| rb_data | output | 32 | Updated base value |
| fault | output | 1 | Invalid-encoding pulse |

## Verification
The bench drives `start` for one cycle. The request, with its address, size, write enable and store data, is due one cycle later. The bench checks it there and again on every cycle of a response delay of zero to three cycles. The write strobes and their data are due in the single cycle after the response is taken, and the bench also checks that they are low one cycle later. A fault is due one cycle after `start`; the bench checks that it is gone in the next cycle and that no request appeared. All sampling happens on the falling clock edge. Expected values come from a behavioural model that uses 64-bit integer arithmetic.

// File: rtl/lsu_xfer_pkg.sv
package lsu_xfer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEM    = 2'd1,
    ST_COMMIT = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic       load;
    logic       sign_ext;
    xfer_size_e size;
    logic       wback;
    logic       pre;
    logic       up;
    logic       reg_off;
    logic       base_pc;
  } xfer_ctl_t;

  localparam logic [3:0] PC_IDX = 4'd15;

endpackage

// File: rtl/lsu_xfer_decode.sv
module lsu_xfer_decode
  import lsu_xfer_pkg::*;
(
  input  logic       half_fmt,
  input  logic       b_imm_n,
  input  logic       b_pre,
  input  logic       b_up,
  input  logic       b_sz,
  input  logic       b_wb,
  input  logic       b_ld,
  input  logic [1:0] b_sh,
  input  logic       b_rsh,
  input  logic [3:0] rn_num,
  input  logic [3:0] rm_num,
  output xfer_ctl_t  ctl,
  output logic       bad
);

  always_comb begin
    ctl          = '0;
    ctl.pre      = b_pre;
    ctl.up       = b_up;
    ctl.load     = b_ld;
    ctl.wback    = b_wb | ~b_pre;
    bad          = ~b_pre & b_wb;
    if (!half_fmt) begin
      ctl.size     = b_sz ? SZ_BYTE : SZ_WORD;
      ctl.sign_ext = 1'b0;
      ctl.reg_off  = b_imm_n;
      ctl.base_pc  = (rn_num == PC_IDX);
      if (b_imm_n && b_rsh) bad = 1'b1;
      if ((rn_num == PC_IDX) && (b_wb | ~b_pre)) bad = 1'b1;
    end else begin
      ctl.reg_off = ~b_sz;
      ctl.base_pc = 1'b0;
      unique case (b_sh)
        2'b10: begin ctl.size = SZ_BYTE; ctl.sign_ext = b_ld; end
        2'b01: begin ctl.size = SZ_HALF; ctl.sign_ext = 1'b0; end
        2'b11: begin ctl.size = SZ_HALF; ctl.sign_ext = b_ld; end
        default: begin ctl.size = SZ_HALF; ctl.sign_ext = 1'b0; bad = 1'b1; end
      endcase
      if (!b_sz && (rm_num == PC_IDX)) bad = 1'b1;
    end
  end

endmodule

// File: rtl/lsu_offset_gen.sv
module lsu_offset_gen #(
  parameter int XLEN = 32
) (
  input  logic            half_fmt,
  input  logic            reg_off,
  input  logic [11:0]     imm_bits,
  input  logic [XLEN-1:0] rm_val,
  output logic [XLEN-1:0] off_mag
);

  localparam int AW = $clog2(XLEN);

  logic [AW-1:0]   amt;
  logic [1:0]      kind;
  logic [XLEN-1:0] shifted;

  assign amt  = imm_bits[11:7];
  assign kind = imm_bits[6:5];

  always_comb begin
    shifted = rm_val;
    if (amt != '0) begin
      unique case (kind)
        2'd0: shifted = rm_val << amt;
        2'd1: shifted = rm_val >> amt;
        2'd2: shifted = XLEN'($signed(rm_val) >>> amt);
        default: shifted = (rm_val >> amt) | (rm_val << (XLEN - int'(amt)));
      endcase
    end
  end

  always_comb begin
    if (half_fmt) begin
      off_mag = reg_off ? rm_val : XLEN'({imm_bits[11:8], imm_bits[3:0]});
    end else begin
      off_mag = reg_off ? shifted : XLEN'(imm_bits);
    end
  end

endmodule

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc #(
  parameter int XLEN   = 32,
  parameter int PC_ADJ = 4
) (
  input  logic            base_pc,
  input  logic            pre,
  input  logic            up,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] pc_val,
  input  logic [XLEN-1:0] off_mag,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] moved
);

  logic [XLEN-1:0] base_eff;

  assign base_eff = base_pc ? (pc_val + XLEN'(PC_ADJ)) : base_val;
  assign moved    = up ? (base_eff + off_mag) : (base_eff - off_mag);
  assign addr     = pre ? moved : base_eff;

endmodule

// File: rtl/lsu_data_fmt.sv
module lsu_data_fmt
  import lsu_xfer_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ST_ADJ  = 8
) (
  input  xfer_size_e      size,
  input  logic            sign_ext,
  input  logic            src_is_pc,
  input  logic [XLEN-1:0] st_src,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ld_ext
);

  logic [XLEN-1:0] st_val;

  assign st_val = src_is_pc ? (st_src + XLEN'(ST_ADJ)) : st_src;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        wdata  = XLEN'(st_val[7:0]);
        ld_ext = sign_ext ? {{(XLEN-8){rdata[7]}}, rdata[7:0]} : XLEN'(rdata[7:0]);
      end
      SZ_HALF: begin
        wdata  = XLEN'(st_val[15:0]);
        ld_ext = sign_ext ? {{(XLEN-16){rdata[15]}}, rdata[15:0]} : XLEN'(rdata[15:0]);
      end
      default: begin
        wdata  = st_val;
        ld_ext = rdata;
      end
    endcase
  end

endmodule

// File: rtl/lsu_xfer_fmt.sv
module lsu_xfer_fmt
  import lsu_xfer_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            half_fmt,
  input  logic [25:0]     instr,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] offs_val,
  input  logic [XLEN-1:0] data_val,
  input  logic [XLEN-1:0] pc_val,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_resp_valid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            rd_we,
  output logic [RIW-1:0]  rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            rb_we,
  output logic [RIW-1:0]  rb_idx,
  output logic [XLEN-1:0] rb_data,
  output logic            fault
);

  xfer_ctl_t   ctl_live;
  logic        bad_live;

  xfer_state_e state_q, state_d;
  logic        fault_q, fault_d;
  logic        cap_en, ld_en;

  xfer_ctl_t       ctl_q;
  logic            half_q;
  logic [11:0]     imm_q;
  logic [RIW-1:0]  rd_q, rn_q;
  logic [XLEN-1:0] base_q, rm_q, data_q, pc_q, ld_q;

  logic [XLEN-1:0] off_mag, addr_w, moved_w, wdata_w, ld_w;

  lsu_xfer_decode u_dec (
    .half_fmt (half_fmt),
    .b_imm_n  (instr[25]),
    .b_pre    (instr[24]),
    .b_up     (instr[23]),
    .b_sz     (instr[22]),
    .b_wb     (instr[21]),
    .b_ld     (instr[20]),
    .b_sh     (instr[6:5]),
    .b_rsh    (instr[4]),
    .rn_num   (instr[19:16]),
    .rm_num   (instr[3:0]),
    .ctl      (ctl_live),
    .bad      (bad_live)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    fault_d = 1'b0;
    cap_en  = 1'b0;
    ld_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (bad_live) begin
            fault_d = 1'b1;
          end else begin
            cap_en  = 1'b1;
            state_d = ST_MEM;
          end
        end
      end
      ST_MEM: begin
        if (mem_resp_valid) begin
          ld_en   = 1'b1;
          state_d = ST_COMMIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  // operand capture, enabled on accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      half_q <= 1'b0;
      imm_q  <= '0;
      rd_q   <= '0;
      rn_q   <= '0;
      base_q <= '0;
      rm_q   <= '0;
      data_q <= '0;
      pc_q   <= '0;
    end else if (cap_en) begin
      ctl_q  <= ctl_live;
      half_q <= half_fmt;
      imm_q  <= instr[11:0];
      rd_q   <= instr[15:12];
      rn_q   <= instr[19:16];
      base_q <= base_val;
      rm_q   <= offs_val;
      data_q <= data_val;
      pc_q   <= pc_val;
    end
  end

  // load result capture, enabled on response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= '0;
    end else if (ld_en) begin
      ld_q <= ld_w;
    end
  end

  lsu_offset_gen #(.XLEN(XLEN)) u_off (
    .half_fmt (half_q),
    .reg_off  (ctl_q.reg_off),
    .imm_bits (imm_q),
    .rm_val   (rm_q),
    .off_mag  (off_mag)
  );

  lsu_addr_calc #(.XLEN(XLEN)) u_addr (
    .base_pc  (ctl_q.base_pc),
    .pre      (ctl_q.pre),
    .up       (ctl_q.up),
    .base_val (base_q),
    .pc_val   (pc_q),
    .off_mag  (off_mag),
    .addr     (addr_w),
    .moved    (moved_w)
  );

  lsu_data_fmt #(.XLEN(XLEN)) u_data (
    .size      (ctl_q.size),
    .sign_ext  (ctl_q.sign_ext),
    .src_is_pc (rd_q == RIW'(PC_IDX)),
    .st_src    (data_q),
    .rdata     (mem_rdata),
    .wdata     (wdata_w),
    .ld_ext    (ld_w)
  );

  assign mem_req_valid = (state_q == ST_MEM);
  assign mem_addr      = addr_w;
  assign mem_size      = ctl_q.size;
  assign mem_we        = ~ctl_q.load;
  assign mem_wdata     = wdata_w;
  assign rd_we         = (state_q == ST_COMMIT) & ctl_q.load;
  assign rd_idx        = rd_q;
  assign rd_data       = ld_q;
  assign rb_we         = (state_q == ST_COMMIT) & ctl_q.wback;
  assign rb_idx        = rn_q;
  assign rb_data       = moved_w;
  assign fault         = fault_q;

  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req_valid && !rd_we && !rb_we));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_resp_valid) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata)
       && $stable(mem_we) && $stable(mem_size)));

  p_commit_after_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || rb_we) |-> $past(mem_req_valid && mem_resp_valid));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || rb_we) |=> (!rd_we && !rb_we));

  p_size_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_size != 2'b11));

  p_load_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $past(!mem_we));

endmodule

// File: tb/lsu_xfer_fmt_tb_top.sv
module lsu_xfer_fmt_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        half_fmt;
  logic [25:0] instr;
  logic [31:0] base_val, offs_val, data_val, pc_val;
  logic        mem_req_valid;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic        mem_resp_valid;
  logic [31:0] mem_rdata;
  logic        rd_we;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        rb_we;
  logic [3:0]  rb_idx;
  logic [31:0] rb_data;
  logic        fault;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 0;

  lsu_xfer_fmt dut_i (
    .clk, .rst_n, .start, .half_fmt, .instr, .base_val, .offs_val,
    .data_val, .pc_val, .mem_req_valid, .mem_addr, .mem_size, .mem_we,
    .mem_wdata, .mem_resp_valid, .mem_rdata, .rd_we, .rd_idx, .rd_data,
    .rb_we, .rb_idx, .rb_data, .fault
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // word/byte class instruction builder
  function automatic logic [25:0] mk_wb(bit i, bit p, bit u, bit b, bit w, bit l,
                                        int rn, int rd, int low12);
    logic [25:0] v;
    v = '0;
    v[25] = i; v[24] = p; v[23] = u; v[22] = b; v[21] = w; v[20] = l;
    v[19:16] = 4'(rn); v[15:12] = 4'(rd); v[11:0] = 12'(low12);
    return v;
  endfunction

  // halfword class instruction builder
  function automatic logic [25:0] mk_hf(bit p, bit u, bit imm, bit w, bit l,
                                        int rn, int rd, int hi4, bit s, bit h, int lo4);
    logic [25:0] v;
    v = '0;
    v[24] = p; v[23] = u; v[22] = imm; v[21] = w; v[20] = l;
    v[19:16] = 4'(rn); v[15:12] = 4'(rd); v[11:8] = 4'(hi4);
    v[7] = 1'b1; v[6] = s; v[5] = h; v[4] = 1'b1; v[3:0] = 4'(lo4);
    return v;
  endfunction

  // behavioural reference model
  task automatic model(input logic [25:0] ins, input bit hf,
                       input longint base, input longint rm, input longint dat,
                       input longint pc, input longint rdv,
                       output bit bad, output longint addr, output int size,
                       output bit we, output longint wdat, output longint ld,
                       output bit wb, output longint newbase);
    longint off, b0, moved, mask, st;
    int amt, typ, rn, rd;
    bit p, u, l, w;
    p = ins[24]; u = ins[23]; w = ins[21]; l = ins[20];
    rn = int'(ins[19:16]); rd = int'(ins[15:12]);
    bad = (!p && w);
    wb  = w || !p;
    we  = !l;
    ld  = 0;
    if (!hf) begin
      size = ins[22] ? 1 : 4;
      if (ins[25]) begin
        if (ins[4]) bad = 1;
        amt = int'(ins[11:7]); typ = int'(ins[6:5]);
        off = rm & 64'hFFFF_FFFF;
        if (amt != 0) begin
          case (typ)
            0: off = (off * (64'd1 << amt)) & 64'hFFFF_FFFF;
            1: off = off / (64'd1 << amt);
            2: off = longint'($signed(rm[31:0]) >>> amt) & 64'hFFFF_FFFF;
            default: off = ((off >> amt) | (off << (32 - amt))) & 64'hFFFF_FFFF;
          endcase
        end
      end else off = longint'(ins[11:0]);
      if (rn == 15) begin
        b0 = pc + 4;
        if (wb) bad = 1;
      end else b0 = base;
      if (size == 1) ld = rdv & 255; else ld = rdv & 64'hFFFF_FFFF;
    end else begin
      if (ins[22]) off = longint'(ins[11:8]) * 16 + longint'(ins[3:0]);
      else begin
        off = rm & 64'hFFFF_FFFF;
        if (ins[3:0] == 4'hF) bad = 1;
      end
      b0 = base;
      if (ins[6] && !ins[5]) begin
        size = 1;
        ld = (rdv & 128) ? ((rdv & 255) | 64'hFFFF_FF00) : (rdv & 255);
      end else if (ins[5]) begin
        size = 2;
        if (ins[6] && (rdv & 32768)) ld = (rdv & 65535) | 64'hFFFF_0000;
        else ld = rdv & 65535;
      end else begin
        size = 2; bad = 1;
      end
    end
    moved   = (u ? (b0 + off) : (b0 - off)) & 64'hFFFF_FFFF;
    addr    = p ? moved : (b0 & 64'hFFFF_FFFF);
    newbase = moved;
    mask    = (64'd1 << (size * 8)) - 1;
    st      = (rd == 15) ? dat + 8 : dat;
    wdat    = st & mask;
  endtask

  function automatic int size_code(int bytes);
    return (bytes == 1) ? 0 : (bytes == 2) ? 1 : 2;
  endfunction

  task automatic xfer(string req, logic [25:0] ins, bit hf, longint base, longint rm,
                      longint dat, longint pc, longint rdv, int delay);
    bit bad, we, wb;
    longint addr, wdat, ld, nb;
    int size;
    model(ins, hf, base, rm, dat, pc, rdv, bad, addr, size, we, wdat, ld, wb, nb);
    @(negedge clk);
    instr = ins; half_fmt = hf; base_val = base[31:0]; offs_val = rm[31:0];
    data_val = dat[31:0]; pc_val = pc[31:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      // R11: fault pulse one cycle after start, nothing else
      chk(req, "R11 fault", fault, 1);
      chk(req, "R11 no req", mem_req_valid, 0);
      @(negedge clk);
      chk(req, "R11 fault one cycle", fault, 0);
      chk(req, "R11 still no req", mem_req_valid, 0);
      chk(req, "R11 no rd_we", rd_we, 0);
      chk(req, "R11 no rb_we", rb_we, 0);
      return;
    end
    // R10: request due one cycle after start
    chk(req, "R10 req", mem_req_valid, 1);
    chk(req, "addr", mem_addr, addr);
    chk(req, "size", mem_size, size_code(size));
    chk(req, "we", mem_we, we);
    if (we) chk(req, "wdata", mem_wdata, wdat);
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk(req, "R10 req held", mem_req_valid, 1);
      chk(req, "R10 addr held", mem_addr, addr);
      chk(req, "R10 no early write", rd_we | rb_we, 0);
    end
    mem_resp_valid = 1'b1;
    mem_rdata = rdv[31:0];
    @(negedge clk);
    mem_resp_valid = 1'b0;
    mem_rdata = 32'hA5A5_5A5A;
    chk(req, "R10 req dropped", mem_req_valid, 0);
    chk(req, "R10 rd_we", rd_we, !we);
    chk(req, "R5 rb_we", rb_we, wb);
    if (!we) begin
      chk(req, "rd_idx", rd_idx, longint'(ins[15:12]));
      chk(req, "rd_data", rd_data, ld);
    end
    if (wb) begin
      chk(req, "R5 rb_idx", rb_idx, longint'(ins[19:16]));
      chk(req, "R4 rb_data", rb_data, nb);
    end
    @(negedge clk);
    chk(req, "R10 strobes one cycle", rd_we | rb_we, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; half_fmt = 1'b0; instr = '0;
    base_val = '0; offs_val = '0; data_val = '0; pc_val = '0;
    mem_resp_valid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("reset", "req", mem_req_valid, 0);
    chk("reset", "fault", fault, 0);
    chk("reset", "rd_we", rd_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R6: word load, immediate, pre-index, no writeback
    xfer("R1", mk_wb(0,1,1,0,0,1, 2,3, 12'h010), 0, 32'h1000, 0, 0, 32'h8000, 32'hDEADBEEF, 0);
    // R3 R4 R5 R6 R9: byte store, post-index down, writeback
    xfer("R3", mk_wb(0,0,0,1,0,0, 4,5, 12'h004), 0, 32'h2000, 0, 32'h12345678, 32'h8000, 0, 2);
    // R1: shifted register offsets, each type, pre with writeback
    xfer("R1", mk_wb(1,1,1,0,1,1, 1,2, (2<<7)|(0<<5)), 0, 32'h3000, 3, 0, 0, 32'h11, 1);
    xfer("R1", mk_wb(1,1,1,0,0,1, 1,2, (4<<7)|(1<<5)), 0, 32'h3000, 32'h80000100, 0, 0, 32'h22, 0);
    xfer("R1", mk_wb(1,1,0,0,0,1, 1,2, (4<<7)|(2<<5)), 0, 32'h3000, 32'h80000000, 0, 0, 32'h33, 0);
    xfer("R1", mk_wb(1,1,1,0,0,0, 1,2, (8<<7)|(3<<5)), 0, 32'h0, 32'h000000AB, 32'h55, 0, 0, 1);
    xfer("R1", mk_wb(1,1,1,0,0,1, 1,2, (0<<7)|(1<<5)), 0, 32'h100, 32'h40, 0, 0, 32'h1, 0);
    // R6: byte load zero-extended
    xfer("R6", mk_wb(0,1,1,1,0,1, 6,7, 12'h001), 0, 32'h4000, 0, 0, 0, 32'hFFFF_FFF0, 3);
    // R8: base register 15 uses pc+4
    xfer("R8", mk_wb(0,1,0,0,0,1, 15,1, 12'h008), 0, 32'h0, 0, 0, 32'h9000, 32'h7, 0);
    xfer("R8", mk_wb(0,1,1,0,1,1, 15,1, 12'h008), 0, 32'h0, 0, 0, 32'h9000, 0, 0);
    xfer("R8", mk_wb(0,0,1,0,0,1, 15,1, 12'h008), 0, 32'h0, 0, 0, 32'h9000, 0, 0);
    // R9: store of register 15 adds 8
    xfer("R9", mk_wb(0,1,1,0,0,0, 2,15, 12'h000), 0, 32'h5000, 0, 32'h0000_1234, 0, 0, 0);
    xfer("R9", mk_wb(0,1,1,1,0,0, 2,15, 12'h000), 0, 32'h5000, 0, 32'h0000_12FC, 0, 0, 0);
    // R5 R11: post-index with writeback bit is invalid
    xfer("R5", mk_wb(0,0,1,0,1,1, 2,3, 12'h004), 0, 32'h5000, 0, 0, 0, 0, 0);
    // R1 R11: register offset with bit 4 set is invalid
    xfer("R1", mk_wb(1,1,1,0,0,1, 2,3, 12'h010), 0, 32'h5000, 0, 0, 0, 0, 0);
    // R2 R7: split immediate, signed byte load
    xfer("R7", mk_hf(1,1,1,0,1, 8,9, 4'h1, 1,0, 4'h2), 1, 32'h6000, 0, 0, 0, 32'h0000_0080, 1);
    // R7: signed halfword load, unsigned halfword load
    xfer("R7", mk_hf(1,0,1,1,1, 8,9, 4'h0, 1,1, 4'h2), 1, 32'h6000, 0, 0, 0, 32'h1234_8001, 0);
    xfer("R7", mk_hf(1,1,1,0,1, 8,9, 4'h0, 0,1, 4'h2), 1, 32'h6000, 0, 0, 0, 32'h1234_8001, 2);
    // R7: halfword store with S set, byte store with S alone
    xfer("R7", mk_hf(1,1,1,0,0, 8,9, 4'h0, 1,1, 4'h4), 1, 32'h6000, 0, 32'hCAFE_BEEF, 0, 0, 0);
    xfer("R7", mk_hf(1,1,1,0,0, 8,9, 4'h0, 1,0, 4'h4), 1, 32'h6000, 0, 32'hCAFE_BEEF, 0, 0, 1);
    // R2 R3 R4: register offset, post-index down, halfword store
    xfer("R2", mk_hf(0,0,0,0,0, 8,9, 4'h0, 0,1, 4'h3), 1, 32'h7000, 32'h20, 32'h0000_ABCD, 0, 0, 3);
    // R2 R11: register 15 as offset register is invalid
    xfer("R2", mk_hf(1,1,0,0,1, 8,9, 4'h0, 0,1, 4'hF), 1, 32'h7000, 0, 0, 0, 0, 0);
    // R7 R11: S=H=0 in halfword class is invalid
    xfer("R7", mk_hf(1,1,1,0,1, 8,9, 4'h0, 0,0, 4'h1), 1, 32'h7000, 0, 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule